// File: doc/BRIEF.md
# Configurable Interrupt Input Conditioner

This block sits between a set of raw, asynchronous interrupt lines and an interrupt controller core. Each input is set up at build time to be either edge-sensitive or level-sensitive. An edge input can fire on the rising or on the falling transition. A level input can be active-high or active-low. Edge inputs pass through a synchronizer and produce a single one-cycle detect pulse for each active transition. Level inputs drive their detect bit for as long as the line sits at its active level.

The block also shapes the core's combined request into the interrupt output pin. In level mode the pin holds its active value while the request is present. In pulse mode the pin gives one active clock on each new request. The active value of the pin is set by a polarity parameter. Every choice is made by a parameter vector, one bit per input, so a single instance can serve mixed interrupt sources.

Top module: `irq_input_conditioner`

## Requirements
- R1: While reset is high, every edge-input detect bit is 0. The output pin holds its inactive value (0 when `OUT_POL`=1, 1 when `OUT_POL`=0) during reset and in the first cycle after it.
- R2: An input with a 1 in `SENSE_KIND` and a 1 in `EDGE_RISE` raises its detect bit for exactly one clock on a 0-to-1 line change. The change is captured at clock edge k, and detect is high between edges k+1 and k+2.
- R3: An input with a 1 in `SENSE_KIND` and a 0 in `EDGE_RISE` raises its detect bit for exactly one clock on a 1-to-0 line change, with the same latency as R2.
- R4: An edge input that is held at its active value for a single clock and then returns produces exactly one detect pulse. An input held active for many clocks also produces exactly one.
- R5: An input with a 0 in `SENSE_KIND` and a 1 in `LEVEL_HIGH` has its detect bit equal to the line, with no clock delay. The detect stays high for as long as the line is high.
- R6: An input with a 0 in `SENSE_KIND` and a 0 in `LEVEL_HIGH` has its detect bit equal to the inverted line, with no clock delay.
- R7: With `OUT_LEVEL`=1, the pin takes its active value at the clock edge after `req_in` rises. It holds that value while `req_in` stays high and returns to inactive at the clock edge after `req_in` falls.
- R8: With `OUT_LEVEL`=0, each 0-to-1 change of `req_in` gives exactly one clock of active pin value, starting at the next clock edge. A request that stays high gives no further pulse.
- R9: With `OUT_POL`=0, the pin rests at 1 and its active value is 0. This holds in both output modes.
- R10: A transition of an edge input towards its inactive value produces no detect pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_raw | input | N_IN | Raw asynchronous interrupt lines |
| det | output | N_IN | Per-input detect, a pulse for edge inputs and a level for level inputs |
| req_in | input | 1 | Combined request from the controller core |
| irq_pin | output | 1 | Shaped interrupt output pin |

## Verification
Edge inputs are driven with a long active level, with a one-clock glitch towards the active value, and with a move back towards the inactive value. These separate a single correct pulse from a missed event, a doubled event and a pulse on the wrong transition. The pulse position also pins the synchronizer depth to exactly two stages before the comparison. Level inputs are held for several clocks at each polarity, which shows a direct combinational follow and rules out a hidden register. The request path is driven through a held request and a repeated request on two instances. One instance uses a high level output and the other a low pulse output, so stretched pulses, repeated pulses and inverted rest values all show up.

// File: rtl/irq_cond_pkg.sv
`timescale 1ns/1ps
package irq_cond_pkg;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } sense_e;

    typedef enum logic {
        SHAPE_PULSE = 1'b0,
        SHAPE_LEVEL = 1'b1
    } shape_e;

    // resting value of a line or pin whose active value is act
    function automatic logic idle_of(input logic act);
        return ~act;
    endfunction

    // drive value for a pin of polarity act when asserted is on
    function automatic logic pin_value(input logic asserted, input logic act);
        return asserted ? act : ~act;
    endfunction

endpackage

// File: rtl/irq_edge_chan.sv
`timescale 1ns/1ps
module irq_edge_chan
    import irq_cond_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic RISE        = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic line,
    output logic hit
);
    localparam int   CHAIN = SYNC_STAGES + 1;
    localparam logic IDLE  = idle_of(RISE);

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {CHAIN{IDLE}};
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], line};
        end
    end

    // newest synchronized sample vs the one before it
    logic cur_s, old_s;
    assign cur_s = chain_q[CHAIN-2];
    assign old_s = chain_q[CHAIN-1];

    generate
        if (RISE) begin : g_rise
            assign hit = cur_s & ~old_s;
        end else begin : g_fall
            assign hit = ~cur_s & old_s;
        end
    endgenerate
endmodule

// File: rtl/irq_level_chan.sv
`timescale 1ns/1ps
module irq_level_chan #(
    parameter logic HIGH = 1'b1
) (
    input  logic line,
    output logic hit
);
    generate
        if (HIGH) begin : g_high
            assign hit = line;
        end else begin : g_low
            assign hit = ~line;
        end
    endgenerate
endmodule

// File: rtl/irq_out_shaper.sv
`timescale 1ns/1ps
module irq_out_shaper
    import irq_cond_pkg::*;
#(
    parameter logic SHAPE = 1'b1,
    parameter logic POL   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic pin
);
    localparam logic IDLE = idle_of(POL);

    logic req_prev_q;
    logic pin_q;
    logic fire;

    generate
        if (shape_e'(SHAPE) == SHAPE_LEVEL) begin : g_level
            assign fire = req;
        end else begin : g_pulse
            assign fire = req & ~req_prev_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            req_prev_q <= 1'b0;
            pin_q      <= IDLE;
        end else begin
            req_prev_q <= req;
            pin_q      <= pin_value(fire, POL);
        end
    end

    assign pin = pin_q;
endmodule

// File: rtl/irq_input_conditioner.sv
`timescale 1ns/1ps
module irq_input_conditioner
    import irq_cond_pkg::*;
#(
    parameter int            N_IN        = 8,
    parameter int            SYNC_STAGES = 2,
    parameter logic [N_IN-1:0] SENSE_KIND = 8'h0F,
    parameter logic [N_IN-1:0] EDGE_RISE  = 8'h05,
    parameter logic [N_IN-1:0] LEVEL_HIGH = 8'h30,
    parameter logic          OUT_LEVEL   = 1'b1,
    parameter logic          OUT_POL     = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_IN-1:0] irq_raw,
    output logic [N_IN-1:0] det,
    input  logic            req_in,
    output logic            irq_pin
);
    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            if (sense_e'(SENSE_KIND[i]) == SENSE_EDGE) begin : g_edge
                irq_edge_chan #(
                    .SYNC_STAGES(SYNC_STAGES),
                    .RISE       (EDGE_RISE[i])
                ) u_chan (
                    .clk (clk),
                    .rst (rst),
                    .line(irq_raw[i]),
                    .hit (det[i])
                );
            end else begin : g_lvl
                irq_level_chan #(
                    .HIGH(LEVEL_HIGH[i])
                ) u_chan (
                    .line(irq_raw[i]),
                    .hit (det[i])
                );
            end
        end
    endgenerate

    irq_out_shaper #(
        .SHAPE(OUT_LEVEL),
        .POL  (OUT_POL)
    ) u_shape (
        .clk(clk),
        .rst(rst),
        .req(req_in),
        .pin(irq_pin)
    );
endmodule

// File: rtl/irq_cond_chk.sv
`timescale 1ns/1ps
module irq_cond_chk #(
    parameter int              N_IN       = 8,
    parameter logic [N_IN-1:0] SENSE_KIND = '0,
    parameter logic [N_IN-1:0] EDGE_RISE  = '0,
    parameter logic            OUT_LEVEL  = 1'b1,
    parameter logic            OUT_POL    = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic [N_IN-1:0] det,
    input logic            req_in,
    input logic            irq_pin
);
    logic req_seen_q;
    always_ff @(posedge clk) begin
        if (rst) req_seen_q <= 1'b0;
        else     req_seen_q <= req_in;
    end

    // R1
    pin_idle_after_reset_chk: assert property (@(posedge clk)
        rst |=> (irq_pin == ~OUT_POL));

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_bit
            if (SENSE_KIND[i]) begin : g_edge
                // R2 R3 R4
                edge_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
                    det[i] |=> !det[i]);
                // R1
                edge_quiet_in_reset_chk: assert property (@(posedge clk)
                    rst |=> !det[i]);
            end
        end
    endgenerate

    generate
        if (OUT_LEVEL) begin : g_lvl
            // R7
            level_follow_on_chk: assert property (@(posedge clk) disable iff (rst)
                req_in |=> (irq_pin == OUT_POL));
            // R7
            level_follow_off_chk: assert property (@(posedge clk) disable iff (rst)
                !req_in |=> (irq_pin == ~OUT_POL));
        end else begin : g_pls
            // R8
            pulse_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
                (irq_pin == OUT_POL) |=> (irq_pin == ~OUT_POL));
            // R8
            pulse_on_new_req_chk: assert property (@(posedge clk) disable iff (rst)
                (req_in && !req_seen_q) |=> (irq_pin == OUT_POL));
        end
    endgenerate
endmodule

bind irq_input_conditioner irq_cond_chk #(
    .N_IN      (N_IN),
    .SENSE_KIND(SENSE_KIND),
    .EDGE_RISE (EDGE_RISE),
    .OUT_LEVEL (OUT_LEVEL),
    .OUT_POL   (OUT_POL)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .det    (det),
    .req_in (req_in),
    .irq_pin(irq_pin)
);

// File: tb/sim_irq_input_conditioner.sv
`timescale 1ns/1ps
module sim_irq_input_conditioner;
    // bit0 edge rising, bit1 edge falling, bit2 level high, bit3 level low
    localparam logic [3:0] KIND = 4'b0011;
    localparam logic [3:0] RISE = 4'b0001;
    localparam logic [3:0] HIGH = 4'b0100;
    localparam logic [3:0] IDLE_RAW = 4'b1010;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] raw;
    logic       req;
    logic [3:0] det0, det1;
    logic       pin0, pin1;
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_input_conditioner #(.N_IN(4), .SENSE_KIND(KIND), .EDGE_RISE(RISE),
        .LEVEL_HIGH(HIGH), .OUT_LEVEL(1'b1), .OUT_POL(1'b1)) u0 (
        .clk(clk), .rst(rst), .irq_raw(raw), .det(det0), .req_in(req), .irq_pin(pin0));

    irq_input_conditioner #(.N_IN(4), .SENSE_KIND(KIND), .EDGE_RISE(RISE),
        .LEVEL_HIGH(HIGH), .OUT_LEVEL(1'b0), .OUT_POL(1'b0)) u1 (
        .clk(clk), .rst(rst), .irq_raw(raw), .det(det1), .req_in(req), .irq_pin(pin1));

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // drive raw[b]=v at a falling edge, then count detect highs over 6 falling edges
    task automatic edge_probe(input int b, input logic v, output int cnt, output int first);
        cnt = 0; first = 0;
        @(negedge clk); raw[b] = v;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (det0[b]) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; raw = IDLE_RAW; req = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 det edge bits in reset", int'(det0[1:0]), 0);
        check("R1 pin0 idle in reset", int'(pin0), 0);
        check("R9 pin1 idle in reset", int'(pin1), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pin0 idle after reset", int'(pin0), 0);
        check("R1 det edge bits after reset", int'(det0[1:0]), 0);
    endtask

    task automatic t_rise();
        int c, f;
        edge_probe(0, 1'b1, c, f);
        check("R2 rising pulse count", c, 1);
        check("R2 rising pulse position", f, 2);
        check("R4 long active one pulse", c, 1);
        edge_probe(0, 1'b0, c, f);
        check("R10 rising chan ignores fall", c, 0);
    endtask

    task automatic t_fall();
        int c, f;
        edge_probe(1, 1'b0, c, f);
        check("R3 falling pulse count", c, 1);
        check("R3 falling pulse position", f, 2);
        edge_probe(1, 1'b1, c, f);
        check("R10 falling chan ignores rise", c, 0);
    endtask

    task automatic t_glitch(input int b, input logic act);
        int c = 0;
        @(negedge clk); raw[b] = act;
        for (int i = 1; i <= 7; i++) begin
            @(negedge clk);
            if (det0[b]) c++;
            if (i == 1) raw[b] = ~act;
        end
        check(b == 0 ? "R4 one-clock high glitch" : "R4 one-clock low glitch", c, 1);
    endtask

    task automatic t_level();
        @(negedge clk); raw[2] = 1'b1; #1;
        check("R5 level high follows at once", int'(det0[2]), 1);
        repeat (3) @(negedge clk);
        check("R5 level high held", int'(det0[2]), 1);
        raw[2] = 1'b0; #1;
        check("R5 level high released", int'(det0[2]), 0);
        raw[3] = 1'b0; #1;
        check("R6 level low active", int'(det0[3]), 1);
        repeat (2) @(negedge clk);
        check("R6 level low held", int'(det0[3]), 1);
        raw[3] = 1'b1; #1;
        check("R6 level low released", int'(det0[3]), 0);
    endtask

    task automatic t_out_level();
        @(negedge clk); req = 1'b1;
        @(negedge clk);
        check("R7 pin active next edge", int'(pin0), 1);
        repeat (3) @(negedge clk);
        check("R7 pin held", int'(pin0), 1);
        req = 1'b0;
        @(negedge clk);
        check("R7 pin released", int'(pin0), 0);
    endtask

    task automatic t_out_pulse();
        int c, f;
        repeat (2) @(negedge clk);
        check("R9 pulse pin rests high", int'(pin1), 1);
        for (int r = 0; r < 2; r++) begin
            c = 0; f = 0;
            req = 1'b1;
            for (int i = 1; i <= 5; i++) begin
                @(negedge clk);
                if (!pin1) begin
                    c++;
                    if (f == 0) f = i;
                end
            end
            check("R8 one pulse per request", c, 1);
            check("R8 pulse at next edge", f, 1);
            req = 1'b0;
            repeat (2) @(negedge clk);
            check("R9 pin idle high after pulse", int'(pin1), 1);
        end
    endtask

    initial begin
        #1000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_glitch(0, 1'b1);
        t_glitch(1, 1'b0);
        t_level();
        t_out_level();
        t_out_pulse();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule